// File: doc/BRIEF.md
# Fine-Adjust Time-of-Day Counter

This block keeps a free-running time of day for precision time stamping. It runs in the reference clock domain. A 32-bit frequency accumulator adds a programmable rate word on every clock. Each carry out of the accumulator is a time tick. On every tick the sub-second field advances by a programmable step, and a sub-second rollover carries into a 32-bit seconds field. Software tunes the rate word to trim the frequency finely. Software normally sets the step to twice the reference period in nanoseconds and the rate word near mid-range, so a tick comes about every other cycle.

Two rollover modes are offered. In nanosecond mode the sub-second field counts modulo 1,000,000,000. In binary mode it counts modulo 2^31, and one count is roughly 0.465 ns. Software sets up the block through a single write port and restarts time with one command. That command loads seconds and sub-seconds together and clears the accumulator. The current time is always visible on two output buses.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the seconds field, the sub-second field, the accumulator and every register are zero. Time stays at zero while the rate word is zero, even if the step and mode are set.
- R2: On every clock that carries no restart command, the accumulator adds the rate word modulo 2^32. A carry out of bit 31 is a tick.
- R3: On a tick the sub-second field grows by the step register (zero-extended). On a cycle with no tick and no restart command it holds its value.
- R4: With mode bit 0 set (nanosecond mode), a sub-second sum of 1,000,000,000 or more wraps to the sum minus 1,000,000,000 and adds one to seconds. A sum of exactly 999,999,999 does not wrap.
- R5: With mode bit 0 clear (binary mode), a sub-second sum of 2^31 or more wraps to the sum minus 2^31 and adds one to seconds.
- R6: Seconds changes only on a sub-second wrap or a restart, and wraps from 0xFFFFFFFF to zero.
- R7: The restart command loads both staged time values into the time fields in one cycle and clears the accumulator in that same cycle. The next tick then needs a full accumulation from zero.
- R8: A rate-word write takes effect on the clock after the write edge. The accumulation at the write edge still uses the old value, and the time fields are not disturbed.
- R9: Write addresses: 0 rate word, 1 step (low 8 bits), 2 mode (bit 0), 3 staged seconds, 4 staged sub-seconds, 5 restart command (data ignored). Writes to addresses 3 and 4 do not change the visible time until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| time_sec | output | 32 | Current seconds |
| time_subsec | output | 32 | Current sub-seconds (ns or binary units) |

## Verification
The bench checks the sub-second field landing exactly on each mode's modulus, where an off-by-one compare would leave 1,000,000,000 or 2^31 in the field or skip the carry. It also checks the sub-second field reaching 999,999,999 exactly, where the same mistake would carry too soon. It checks seconds wrapping at all ones, where a wrong width would saturate or stick. It restarts time while the accumulator sits at half scale; a restart that fails to clear it would give an early tick one cycle later. It changes the rate word mid-run and counts the ticks on both sides of the write edge, which exposes an update applied a cycle early or late.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int SUB_W   = 32;
  localparam int SEC_W   = 32;
  localparam logic [SUB_W:0] NS_MODULUS  = 33'd1_000_000_000;
  localparam logic [SUB_W:0] BIN_MODULUS = 33'h0_8000_0000;

  typedef enum logic [2:0] {
    SEL_RATE   = 3'd0,
    SEL_STEP   = 3'd1,
    SEL_MODE   = 3'd2,
    SEL_SEC    = 3'd3,
    SEL_SUB    = 3'd4,
    SEL_LOAD   = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic             wrap;
    logic [SUB_W-1:0] value;
  } sub_step_t;

  // Advance the sub-second field by one step and fold it at the mode's modulus.
  function automatic sub_step_t sub_advance(input logic [SUB_W-1:0] cur,
                                            input logic [SUB_W-1:0] step,
                                            input logic             ns_mode);
    sub_step_t         r;
    logic [SUB_W:0]    sum;
    logic [SUB_W:0]    lim;
    sum = {1'b0, cur} + {1'b0, step};
    lim = ns_mode ? NS_MODULUS : BIN_MODULUS;
    if (sum >= lim) begin
      r.wrap  = 1'b1;
      r.value = SUB_W'(sum - lim);
    end else begin
      r.wrap  = 1'b0;
      r.value = sum[SUB_W-1:0];
    end
    return r;
  endfunction
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rate_q,
  output logic [INC_W-1:0]  step_q,
  output logic              ns_mode_q,
  output logic [DATA_W-1:0] stage_sec_q,
  output logic [DATA_W-1:0] stage_sub_q,
  output logic              load_cmd
);
  import ptp_tc_pkg::*;

  assign load_cmd = wr_en && (wr_addr == ADDR_W'(SEL_LOAD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q      <= '0;
      step_q      <= '0;
      ns_mode_q   <= 1'b0;
      stage_sec_q <= '0;
      stage_sub_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(SEL_RATE): rate_q      <= wr_data;
        ADDR_W'(SEL_STEP): step_q      <= wr_data[INC_W-1:0];
        ADDR_W'(SEL_MODE): ns_mode_q   <= wr_data[0];
        ADDR_W'(SEL_SEC):  stage_sec_q <= wr_data;
        ADDR_W'(SEL_SUB):  stage_sub_q <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [ACC_W-1:0] rate,
  output logic [ACC_W-1:0] acc_q,
  output logic             tick
);
  logic [ACC_W:0] sum;

  assign sum  = {1'b0, acc_q} + {1'b0, rate};
  assign tick = sum[ACC_W] && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ptp_tc_clock.sv
module ptp_tc_clock #(
  parameter int INC_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         load,
  input  logic                         ns_mode,
  input  logic [INC_W-1:0]             step,
  input  logic [ptp_tc_pkg::SEC_W-1:0] load_sec,
  input  logic [ptp_tc_pkg::SUB_W-1:0] load_sub,
  output logic [ptp_tc_pkg::SEC_W-1:0] sec_q,
  output logic [ptp_tc_pkg::SUB_W-1:0] sub_q,
  output logic                         wrap
);
  import ptp_tc_pkg::*;

  sub_step_t nxt;

  assign nxt  = sub_advance(sub_q, SUB_W'(step), ns_mode);
  assign wrap = tick && nxt.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (load) begin
      sec_q <= load_sec;
      sub_q <= load_sub;
    end else if (tick) begin
      sub_q <= nxt.value;
      if (nxt.wrap) sec_q <= sec_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int INC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [31:0]       time_sec,
  output logic [31:0]       time_subsec
);
  logic [DATA_W-1:0] rate_val;
  logic [INC_W-1:0]  step_val;
  logic              ns_mode;
  logic [DATA_W-1:0] stage_sec;
  logic [DATA_W-1:0] stage_sub;
  logic              load_cmd;
  logic [DATA_W-1:0] acc_val;
  logic              acc_tick;
  logic              sub_wrap;

  ptp_tc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate_q(rate_val), .step_q(step_val), .ns_mode_q(ns_mode),
    .stage_sec_q(stage_sec), .stage_sub_q(stage_sub), .load_cmd(load_cmd)
  );

  ptp_tc_accum #(.ACC_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(load_cmd), .rate(rate_val),
    .acc_q(acc_val), .tick(acc_tick)
  );

  ptp_tc_clock #(.INC_W(INC_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .tick(acc_tick), .load(load_cmd), .ns_mode(ns_mode),
    .step(step_val), .load_sec(stage_sec), .load_sub(stage_sub),
    .sec_q(time_sec), .sub_q(time_subsec), .wrap(sub_wrap)
  );
endmodule

// File: rtl/ptp_time_counter_chk.sv
module ptp_time_counter_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_cmd,
  input logic              acc_tick,
  input logic              sub_wrap,
  input logic              ns_mode,
  input logic [DATA_W-1:0] acc_val,
  input logic [DATA_W-1:0] rate_val,
  input logic [DATA_W-1:0] stage_sec,
  input logic [DATA_W-1:0] stage_sub,
  input logic [31:0]       time_sec,
  input logic [31:0]       time_subsec
);
  assert_acc_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_cmd |=> acc_val == DATA_W'($past(acc_val) + $past(rate_val)));

  assert_sub_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_tick && !load_cmd) |=> $stable(time_subsec));

  assert_ns_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_mode && !load_cmd && time_subsec < 32'd1_000_000_000)
      |=> time_subsec < 32'd1_000_000_000);

  assert_sec_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_wrap && !load_cmd) |=> $stable(time_sec));

  assert_sec_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_wrap && !load_cmd) |=> time_sec == 32'($past(time_sec) + 32'd1));

  assert_load_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_cmd |=> (time_sec == $past(stage_sec)) && (time_subsec == $past(stage_sub))
                 && (acc_val == '0));
endmodule

bind ptp_time_counter ptp_time_counter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .acc_tick(acc_tick),
  .sub_wrap(sub_wrap), .ns_mode(ns_mode), .acc_val(acc_val), .rate_val(rate_val),
  .stage_sec(stage_sec), .stage_sub(stage_sub),
  .time_sec(time_sec), .time_subsec(time_subsec)
);

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] time_sec;
  logic [31:0] time_subsec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ptp_time_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .time_sec(time_sec), .time_subsec(time_subsec)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic [31:0] rate;
    logic [7:0]  step;
    logic        ns;
    logic [31:0] sec0;
    logic [31:0] sub0;
    logic [15:0] ncyc;
    logic [31:0] exp_sec;
    logic [31:0] exp_sub;
  } vec_t;

  // Ticks after N cycles from a cleared accumulator = floor(N*rate / 2^32).
  localparam vec_t VECS [0:8] = '{
    '{"R3", 32'h8000_0000, 8'd40, 1'b1, 32'd5, 32'd0, 16'd10, 32'd5, 32'd200},
    '{"R4", 32'h8000_0000, 8'd40, 1'b1, 32'd7, 32'd999_999_960, 16'd2, 32'd8, 32'd0},
    '{"R4", 32'h8000_0000, 8'd40, 1'b1, 32'd11, 32'd999_999_959, 16'd2, 32'd11, 32'd999_999_999},
    '{"R6", 32'h8000_0000, 8'd40, 1'b1, 32'hFFFF_FFFF, 32'd999_999_990, 16'd2, 32'd0, 32'd30},
    '{"R5", 32'h8000_0000, 8'd86, 1'b0, 32'd3, 32'd2_147_483_598, 16'd2, 32'd4, 32'd36},
    '{"R5", 32'h8000_0000, 8'd86, 1'b0, 32'd2, 32'd1000, 16'd4, 32'd2, 32'd1172},
    '{"R2", 32'h4000_0000, 8'd20, 1'b1, 32'd1, 32'd100, 16'd12, 32'd1, 32'd160},
    '{"R2", 32'hFFFF_FFFF, 8'd8, 1'b1, 32'd0, 32'd0, 16'd5, 32'd0, 32'd32},
    '{"R1", 32'h0000_0000, 8'd40, 1'b1, 32'd9, 32'd500, 16'd20, 32'd9, 32'd500}
  };

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] exp_s, input logic [31:0] exp_ss);
    checks++;
    if (time_sec !== exp_s || time_subsec !== exp_ss) begin
      failures++;
      $display("FAIL %s: sec=%0d sub=%0d expected sec=%0d sub=%0d",
               req, time_sec, time_subsec, exp_s, exp_ss);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'd0, 32'd0);

    // R1: step and mode set but rate zero -> time frozen
    wr(3'd1, 32'd40);
    wr(3'd2, 32'd1);
    repeat (20) @(negedge clk);
    check("R1", 32'd0, 32'd0);

    // R9: staged values invisible until restart command
    wr(3'd3, 32'd55);
    wr(3'd4, 32'd77);
    repeat (2) @(negedge clk);
    check("R9", 32'd0, 32'd0);
    wr(3'd5, 32'hDEAD_BEEF);
    check("R9", 32'd55, 32'd77);

    foreach (VECS[i]) begin
      wr(3'd0, VECS[i].rate);
      wr(3'd1, 32'(VECS[i].step));
      wr(3'd2, 32'(VECS[i].ns));
      wr(3'd3, VECS[i].sec0);
      wr(3'd4, VECS[i].sub0);
      wr(3'd5, 32'd0);
      repeat (int'(VECS[i].ncyc)) @(negedge clk);
      check(string'(VECS[i].tag), VECS[i].exp_sec, VECS[i].exp_sub);
    end

    // R7: restart while accumulator is at half scale must clear it
    wr(3'd0, 32'h8000_0000);
    wr(3'd1, 32'd40);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd0);
    @(negedge clk);              // acc = half
    wr(3'd3, 32'd2);             // tick, acc = 0
    wr(3'd4, 32'd100);           // acc = half
    wr(3'd5, 32'd0);             // restart, acc cleared
    check("R7", 32'd2, 32'd100);
    @(negedge clk);              // acc = half, no tick
    check("R7", 32'd2, 32'd100);
    @(negedge clk);
    check("R7", 32'd2, 32'd140);

    // R8: rate change applies from the cycle after the write edge
    wr(3'd1, 32'd10);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd0);             // restart: acc 0, sub 0
    repeat (3) @(negedge clk);   // half, tick(10), half
    check("R8", 32'd2, 32'd10);
    wr(3'd0, 32'h4000_0000);     // old rate used at this edge: tick(20), acc 0
    check("R8", 32'd2, 32'd20);
    repeat (3) @(negedge clk);   // quarter, half, 3/4
    check("R8", 32'd2, 32'd20);
    @(negedge clk);              // wraps: tick(30)
    check("R8", 32'd2, 32'd30);

    finish_run();
  end
endmodule